// File: doc/BRIEF.md
# Bus Turnaround Timeout Controller

This block supervises a bus turnaround on a serial display link. The protocol engine hands the bus to the peripheral and signals it with a one-cycle request pulse in the escape clock domain. If the timer is enabled at that moment, a down-counter starts in the functional clock domain. Its reload value is a 13-bit count, scaled by 16 and/or by 8 when the matching multiplier inputs are set. The peripheral's acceptance, or software dropping the enable, returns the block to idle quietly.

When the counter runs out, the block latches a sticky timeout status, pulses a hardware clear of the timer enable, and forces the link into its stop state through a force-stop output to the PHY. After a programmable minimum hold it runs a fixed recovery sequence: it releases the force, pulses an internal logic reset that leaves configuration and transmit data alone, then pulses a hardware clear of the interface enable, and returns to idle. Turn requests that arrive during recovery are dropped.

Top module: `bta_watchdog`

## Requirements
- R1: While rst_n is low and on the first cycle after it, irq, force_stop, logic_rst, tmr_en_clr and if_en_clr are all 0.
- R2: The reload value is count × (mul16 ? 16 : 1) × (mul8 ? 8 : 1). The request is carried over by a toggle synchronizer and the counter loads on the third functional clock edge after the escape-domain toggle. force_stop rises reload+1 functional cycles after that load edge, so a count of zero gives the shortest timeout.
- R3: A turn request that arrives while tmr_en is 0 does not start the timer, and no timeout follows.
- R4: peri_ack high for one functional cycle while the timer runs returns the block to idle with no force_stop and no interrupt. A later request is accepted again.
- R5: Dropping tmr_en while the timer runs returns the block to idle with no force_stop and no interrupt.
- R6: Timeout sets a sticky status. irq equals that status AND irq_mask, and a one-cycle irq_clr pulse clears the status.
- R7: tmr_en_clr is a one-cycle pulse in the first cycle in which force_stop is high.
- R8: force_stop stays high for exactly stop_min+1 functional cycles.
- R9: After force_stop falls there is one cycle with no output active. logic_rst is then high for exactly one cycle, if_en_clr is high for exactly one cycle in the cycle after that, and the block is then idle.
- R10: A turn request that arrives while the recovery sequence runs is ignored, even if tmr_en is high, and no second timeout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| esc_clk | input | 1 | Escape clock; the domain of turn_req |
| turn_req | input | 1 | One escape-cycle pulse: bus handed to the peripheral |
| tmr_en | input | 1 | Software timer enable bit |
| count | input | 13 | Base timeout count |
| mul16 | input | 1 | Scale the count by 16 |
| mul8 | input | 1 | Scale the count by 8 |
| stop_min | input | 16 | Minimum stop-state hold, in functional cycles minus one |
| peri_ack | input | 1 | Peripheral accepted the turnaround (functional domain) |
| irq_mask | input | 1 | Interrupt mask, 1 = enabled |
| irq_clr | input | 1 | Write-one-to-clear pulse for the timeout status |
| irq | output | 1 | Masked timeout interrupt |
| force_stop | output | 1 | Force the PHY into the stop state |
| logic_rst | output | 1 | One-cycle internal logic reset |
| tmr_en_clr | output | 1 | One-cycle hardware clear of the timer enable |
| if_en_clr | output | 1 | One-cycle hardware clear of the interface enable |

## Verification
The bench measures the timeout delay with random counts and multiplier combinations, including a zero count. A design that swaps or drops a multiplier, or that loads one cycle late, falls outside the narrow latency window. The recovery sequence is checked cycle by cycle, so a hold that is off by one, a reset and interface clear that come in the wrong order, or a pulse that is two cycles wide is reported. The bench also aborts runs through acknowledge and through disable, and injects a request during recovery; a design that leaks an interrupt or restarts the timer from those states shows a spurious force_stop.

// File: rtl/bta_pkg.sv
`timescale 1ns/1ps
// Shared types for the turnaround timeout controller.
package bta_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_STOP,
        ST_RELEASE,
        ST_LRST,
        ST_IFCLR
    } bta_state_t;
endpackage

// File: rtl/bta_pulse_sync.sv
`timescale 1ns/1ps
// Toggle-based pulse synchronizer.
// Each source pulse flips a toggle flop. The toggle goes through SYNC_W
// destination flops, and an edge detector gives a one-cycle pulse.
// Assumes source pulses are spaced further apart than the synchronizer latency,
// and that rst_n is held for several cycles of both clocks.
module bta_pulse_sync #(
    parameter int SYNC_W = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);
    logic            tgl_q;
    logic [SYNC_W:0] sync_q;

    // Flip the toggle once for each source pulse.
    always_ff @(posedge src_clk) begin
        if (!rst_n)         tgl_q <= 1'b0;
        else if (src_pulse) tgl_q <= ~tgl_q;
    end

    // Carry the toggle into the destination domain; one extra flop keeps the edge detector.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_W-1:0], tgl_q};
    end

    assign dst_pulse = sync_q[SYNC_W] ^ sync_q[SYNC_W-1];
endmodule

// File: rtl/bta_dn_counter.sv
`timescale 1ns/1ps
// Loadable down-counter with a zero flag.
// Assumes load and dec are never high together (load wins if they are).
module bta_dn_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down by one when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bta_watchdog.sv
`timescale 1ns/1ps
// Bus turnaround timeout controller.
// Starts a scaled down-counter on a synchronized turn request while the enable
// is set. On expiry it latches a sticky status, forces the stop state for a
// minimum hold, then releases it, pulses a logic reset and clears the
// interface enable, in that order.
// Assumes peri_ack, tmr_en and the configuration inputs are in the clk domain
// and that the configuration stays steady while the timer runs.
module bta_watchdog #(
    parameter int CNT_W  = 13,
    parameter int STOP_W = 16,
    parameter int X16_SH = 4,
    parameter int X8_SH  = 3,
    parameter int SYNC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esc_clk,
    input  logic              turn_req,
    input  logic              tmr_en,
    input  logic [CNT_W-1:0]  count,
    input  logic              mul16,
    input  logic              mul8,
    input  logic [STOP_W-1:0] stop_min,
    input  logic              peri_ack,
    input  logic              irq_mask,
    input  logic              irq_clr,
    output logic              irq,
    output logic              force_stop,
    output logic              logic_rst,
    output logic              tmr_en_clr,
    output logic              if_en_clr
);
    import bta_pkg::*;

    localparam int RLD_W = CNT_W + X16_SH + X8_SH;

    bta_state_t       st_q, st_d;
    logic             req_pulse;
    logic             t_zero, s_zero;
    logic             t_load, t_dec, s_dec, expire;
    logic [RLD_W-1:0] reload;
    logic             irq_q, tclr_q;

    bta_pulse_sync #(.SYNC_W(SYNC_W)) u_sync (
        .src_clk   (esc_clk),
        .dst_clk   (clk),
        .rst_n     (rst_n),
        .src_pulse (turn_req),
        .dst_pulse (req_pulse)
    );

    // Scale the base count by the selected multipliers.
    always_comb begin
        reload = RLD_W'(count);
        if (mul16) reload = reload << X16_SH;
        if (mul8)  reload = reload << X8_SH;
    end

    assign t_load = (st_q == ST_IDLE) && tmr_en && req_pulse;
    assign t_dec  = (st_q == ST_RUN) && !t_zero;
    assign expire = (st_q == ST_RUN) && tmr_en && !peri_ack && t_zero;
    assign s_dec  = (st_q == ST_STOP) && !s_zero;

    bta_dn_counter #(.W(RLD_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (reload),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    bta_dn_counter #(.W(STOP_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (expire),
        .load_val (stop_min),
        .dec      (s_dec),
        .zero     (s_zero)
    );

    // Next-state: disable beats acknowledge, which beats expiry.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (tmr_en && req_pulse) st_d = ST_RUN;
            ST_RUN: begin
                if (!tmr_en || peri_ack) st_d = ST_IDLE;
                else if (t_zero)         st_d = ST_STOP;
            end
            ST_STOP:    if (s_zero) st_d = ST_RELEASE;
            ST_RELEASE: st_d = ST_LRST;
            ST_LRST:    st_d = ST_IFCLR;
            ST_IFCLR:   st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Sticky timeout status (set wins over clear) and the enable-clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            tclr_q <= 1'b0;
        end else begin
            tclr_q <= expire;
            if (expire)       irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign irq        = irq_q & irq_mask;
    assign tmr_en_clr = tclr_q;
    assign force_stop = (st_q == ST_STOP);
    assign logic_rst  = (st_q == ST_LRST);
    assign if_en_clr  = (st_q == ST_IFCLR);
endmodule

// File: rtl/bta_watchdog_chk.sv
`timescale 1ns/1ps
// Checker for the turnaround timeout controller; bound to every instance.
// Observes ports only.
module bta_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_mask,
    input logic irq,
    input logic force_stop,
    input logic logic_rst,
    input logic tmr_en_clr,
    input logic if_en_clr
);
    // R7
    en_clr_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_en_clr |-> $rose(force_stop));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq);

    // R9
    lrst_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_stop) |=> logic_rst);

    // R9
    ifclr_after_lrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        logic_rst |=> (if_en_clr && !logic_rst));

    // R9
    ifclr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_en_clr |=> (!if_en_clr && !force_stop));

    // R9
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({force_stop, logic_rst, if_en_clr}));
endmodule

bind bta_watchdog bta_watchdog_chk u_chk (.*);

// File: tb/sim_bta_watchdog.sv
`timescale 1ns/1ps
module sim_bta_watchdog;
    localparam int  CLK_P    = 10;
    localparam real ESC_HALF = 7.0;

    logic        clk = 1'b0, esc_clk = 1'b0, rst_n = 1'b0;
    logic        turn_req = 1'b0, tmr_en = 1'b0, mul16 = 1'b0, mul8 = 1'b0;
    logic [12:0] count = '0;
    logic [15:0] stop_min = '0;
    logic        peri_ack = 1'b0, irq_mask = 1'b0, irq_clr = 1'b0;
    logic        irq, force_stop, logic_rst, tmr_en_clr, if_en_clr;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;
    initial begin
        #0.3;
        forever #ESC_HALF esc_clk = ~esc_clk;
    end

    bta_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .esc_clk(esc_clk), .turn_req(turn_req),
        .tmr_en(tmr_en), .count(count), .mul16(mul16), .mul8(mul8),
        .stop_min(stop_min), .peri_ack(peri_ack), .irq_mask(irq_mask),
        .irq_clr(irq_clr), .irq(irq), .force_stop(force_stop),
        .logic_rst(logic_rst), .tmr_en_clr(tmr_en_clr), .if_en_clr(if_en_clr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int reload_of(input int c, input bit a, input bit b);
        return c * (a ? 16 : 1) * (b ? 8 : 1);
    endfunction

    task automatic pulse_req();
        @(negedge esc_clk); turn_req = 1'b1;
        @(negedge esc_clk); turn_req = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // Watch for any timeout activity over a window.
    task automatic quiet(input int cyc, input string tag);
        int seen = 0;
        repeat (cyc) begin
            @(negedge clk);
            if (force_stop || tmr_en_clr) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    // Full timeout and recovery with cycle-exact checks.
    task automatic run_timeout(input int c, input bit a, input bit b, input int sm,
                               input bit mk, input bit inject);
        int n, h, rl;
        bit done;
        @(negedge clk);
        count = 13'(c); mul16 = a; mul8 = b; stop_min = 16'(sm);
        irq_mask = mk; irq_clr = 1'b1; tmr_en = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        rl = reload_of(c, a, b);
        @(negedge esc_clk); turn_req = 1'b1;
        fork
            begin @(negedge esc_clk); turn_req = 1'b0; end
        join_none
        n = 0;
        while (!force_stop && n < rl + 20) begin
            @(negedge clk); n++;
        end
        // R2: latency = sync and load (3 to 5 cycles from the request) + reload + 1
        chk(n >= rl + 3 && n <= rl + 6, "R2 timeout delay", n, rl + 4);
        chk(tmr_en_clr == 1'b1, "R7 enable clear with force_stop", tmr_en_clr, 1);
        chk(irq == mk, "R6 irq at expiry", irq, mk);
        tmr_en = 1'b0;
        h = 1;
        done = 0;
        while (!done) begin
            @(negedge clk);
            if (h == 1) chk(tmr_en_clr == 1'b0, "R7 enable clear one cycle", tmr_en_clr, 0);
            if (!force_stop) done = 1;
            else begin
                h++;
                if (inject && h == 3) begin
                    tmr_en = 1'b1;
                    fork pulse_req(); join_none
                end
            end
        end
        chk(h == sm + 1, "R8 stop hold length", h, sm + 1);
        chk(!logic_rst && !if_en_clr, "R9 release cycle quiet", {logic_rst, if_en_clr}, 0);
        @(negedge clk);
        chk(logic_rst && !if_en_clr, "R9 logic reset second", {logic_rst, if_en_clr}, 2);
        @(negedge clk);
        chk(!logic_rst && if_en_clr, "R9 interface clear last", {logic_rst, if_en_clr}, 1);
        @(negedge clk);
        chk(!logic_rst && !if_en_clr && !force_stop, "R9 back to idle",
            {force_stop, logic_rst, if_en_clr}, 0);
        if (inject) begin
            // R10: the request sent during the hold must not start the timer
            quiet(rl + 30, "R10 request during recovery ignored");
            tmr_en = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        chk({irq, force_stop, logic_rst, tmr_en_clr, if_en_clr} == 0, "R1 in reset",
            {irq, force_stop, logic_rst, tmr_en_clr, if_en_clr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({irq, force_stop, logic_rst, tmr_en_clr, if_en_clr} == 0, "R1 after reset",
            {irq, force_stop, logic_rst, tmr_en_clr, if_en_clr}, 0);

        // R3: request with the enable low
        tmr_en = 1'b0; count = 13'd10;
        pulse_req();
        quiet(60, "R3 disabled request ignored");

        // R2: zero count, shortest timeout; x16 only; x8 only; both
        run_timeout(0, 0, 0, 0, 1, 0);
        run_timeout(7, 1, 0, 3, 1, 0);
        run_timeout(9, 0, 1, 1, 0, 0);
        run_timeout(3, 1, 1, 5, 1, 0);

        // R6: sticky status, mask and clear
        repeat (10) @(negedge clk);
        chk(irq == 1'b1, "R6 status sticky", irq, 1);
        irq_mask = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R6 masked", irq, 0);
        irq_mask = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R6 unmask shows status", irq, 1);
        clear_irq();
        @(negedge clk);
        chk(irq == 1'b0, "R6 write-one clear", irq, 0);

        // R4: peripheral accepts in time
        count = 13'd60; mul16 = 0; mul8 = 0; irq_mask = 1'b1; tmr_en = 1'b1;
        pulse_req();
        repeat (20) @(negedge clk);
        peri_ack = 1'b1;
        @(negedge clk); peri_ack = 1'b0;
        quiet(100, "R4 accepted turnaround");
        chk(irq == 1'b0, "R4 no interrupt", irq, 0);
        run_timeout(5, 0, 0, 2, 1, 0);

        // R5: enable dropped while running
        clear_irq();
        count = 13'd60; mul16 = 0; mul8 = 0; tmr_en = 1'b1;
        pulse_req();
        repeat (20) @(negedge clk);
        tmr_en = 1'b0;
        quiet(100, "R5 disabled mid-run");
        chk(irq == 1'b0, "R5 no interrupt", irq, 0);

        // R10: request arriving during the hold
        run_timeout(50, 0, 0, 40, 1, 1);

        // R2 R8 R9: random configurations
        for (int i = 0; i < 12; i++) begin
            int c = 1 + int'($urandom_range(0, 39));
            bit a = 1'($urandom_range(0, 1));
            bit b = 1'($urandom_range(0, 1));
            int sm = int'($urandom_range(0, 15));
            bit mk = 1'($urandom_range(0, 1));
            run_timeout(c, a, b, sm, mk, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule